// File: doc/BRIEF.md
# Link Interrupt Condition Aggregator

This block gathers the interrupt causes of a serial physical-layer controller into one status byte and a single interrupt request. The upper nibble of the status byte carries four causes: a sticky threshold flag from a link error down-counter, two live summaries of masked receive condition registers, and a live summary of two software sense bits. The lower nibble always reads as zero.

Software loads the 8-bit link error counter through a small register port. Each error pulse from the line logic takes one off the count, and the count stops at zero. When the count is zero the threshold flag is set. It stays set until software writes a 1 to its bit and the count is no longer zero. Because the counter resets to zero, the flag is already set when reset ends. Each receive condition register latches event pulses until software clears them by writing 1s. Its summary bit is the OR of the condition bits ANDed with a mask register. Writes to the summary bits in the status byte do nothing. The interrupt request is the OR of the four causes after each is gated by an enable register. Reads and the request output are registered.

Top module: `link_irq_agg`

## Requirements
- R1: After reset the counter reads 0 and the status byte reads 8'h10 (threshold flag set). The masks, condition registers, sense bits and enables read 0, and `irq` is 0.
- R2: A write to address 1 loads the counter with `reg_wdata`. A read of address 1 returns the count.
- R3: Each cycle with `err_pulse` high and no counter load lowers the count by one. At zero the count stays at zero and does not wrap.
- R4: Status bit 4 becomes 1 when the count is zero. It stays 1 until a write to address 0 with `reg_wdata[4]`=1 while the count is nonzero.
- R5: If a clear of status bit 4 falls in a cycle where the count is zero afterwards, bit 4 stays 1. This includes the cycle in which an error pulse takes the count to zero.
- R6: Status bit 5 is the OR over i of (condition A[i] AND mask A[i]), where condition A is address 2 and mask A is address 3. A write to address 0 does not change bits 5, 6 or 7.
- R7: A high bit of `rca_evt`/`rcb_evt` sets the matching bit of condition A/B. Writing 1 to a bit at address 2 or 4 clears that bit. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: Status bit 6 is the OR over i of (condition B[i] AND mask B[i]), where condition B is address 4 and mask B is address 5.
- R9: Status bit 7 is 1 while either sense bit (address 6, bits 1:0) is 1, and 0 only when both are 0.
- R10: `irq` is one cycle behind the status byte: irq = OR of (status[7:4] AND enable[7:4]), with the enable at address 7. Status bits 3:0 and enable bits 3:0 read 0.
- R11: `reg_rdata` shows, one clock edge after `reg_addr` is presented, the value that the addressed register held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| err_pulse | input | 1 | Link error pulse, one per error |
| rca_evt | input | COND_W | Event pulses for condition register A |
| rcb_evt | input | COND_W | Event pulses for condition register B |
| irq | output | 1 | Registered interrupt request |

## Verification
Two pairs of actions can land in the same cycle. The first pair is a software clear of the threshold flag and the error pulse that takes the count to zero. The bench drives the pulse and the status write on the same edge and expects the flag to read back as set. The second pair is an event pulse and a write-1 clear on the same condition bit. The bench drives both together, reads the condition register, and expects the bit still set. It then clears the bit alone to show that the clear itself works.

// File: rtl/lia_pkg.sv
package lia_pkg;
  typedef enum logic [2:0] {
    A_STAT  = 3'd0,
    A_CNT   = 3'd1,
    A_CONDA = 3'd2,
    A_MASKA = 3'd3,
    A_CONDB = 3'd4,
    A_MASKB = 3'd5,
    A_USER  = 3'd6,
    A_IEN   = 3'd7
  } reg_addr_e;

  localparam int STAT_LEM  = 4;
  localparam int STAT_CA   = 5;
  localparam int STAT_CB   = 6;
  localparam int STAT_USER = 7;
  localparam int SENSE_W   = 2;
endpackage

// File: rtl/lia_lem_cnt.sv
module lia_lem_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         flag
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         flag_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                  cnt_d = load_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= (cnt_d == '0) ? 1'b1 : (flag_q & ~clr);
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  // R4
  zero_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> flag_q);
  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));
  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lia_cond.sv
module lia_cond #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_wr,
  input  logic         mask_wr,
  input  logic [W-1:0] wval,
  output logic [W-1:0] cond,
  output logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] cond_q, mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      mask_q <= '0;
    end else begin
      cond_q <= (cond_q & ~(clr_wr ? wval : '0)) | evt;
      if (mask_wr) mask_q <= wval;
    end
  end

  assign cond = cond_q;
  assign mask = mask_q;
  assign hit  = |(cond_q & mask_q);

  // R7
  evt_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((cond_q & $past(evt)) == $past(evt)));
  // R6
  masked_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !hit);
endmodule

// File: rtl/link_irq_agg.sv
module link_irq_agg #(
  parameter int DW     = 8,
  parameter int COND_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              err_pulse,
  input  logic [COND_W-1:0] rca_evt,
  input  logic [COND_W-1:0] rcb_evt,
  output logic              irq
);
  import lia_pkg::*;

  localparam int NCOND = 2;

  logic [DW-1:0]      cnt;
  logic               lem_flag;
  logic [COND_W-1:0]  evt_a [NCOND];
  logic [COND_W-1:0]  cond_a [NCOND];
  logic [COND_W-1:0]  mask_a [NCOND];
  logic [NCOND-1:0]   cond_hit;
  logic [SENSE_W-1:0] sense_q;
  logic [3:0]         ien_q;
  logic [DW-1:0]      stat, rd_d;
  logic [DW-1:0]      rdata_q;
  logic               irq_q;

  wire wr_stat = reg_wr && (reg_addr == A_STAT);
  wire wr_cnt  = reg_wr && (reg_addr == A_CNT);

  lia_lem_cnt #(.W(DW)) u_lem (
    .clk(clk), .rst(rst), .load(wr_cnt), .load_val(reg_wdata),
    .dec(err_pulse), .clr(wr_stat && reg_wdata[STAT_LEM]),
    .cnt(cnt), .flag(lem_flag)
  );

  assign evt_a[0] = rca_evt;
  assign evt_a[1] = rcb_evt;

  for (genvar g = 0; g < NCOND; g++) begin : g_cond
    localparam logic [2:0] CADDR = 3'(A_CONDA + 2 * g);
    localparam logic [2:0] MADDR = 3'(A_MASKA + 2 * g);
    lia_cond #(.W(COND_W)) u_cond (
      .clk(clk), .rst(rst), .evt(evt_a[g]),
      .clr_wr(reg_wr && reg_addr == CADDR),
      .mask_wr(reg_wr && reg_addr == MADDR),
      .wval(reg_wdata[COND_W-1:0]),
      .cond(cond_a[g]), .mask(mask_a[g]), .hit(cond_hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      ien_q   <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_USER) sense_q <= reg_wdata[SENSE_W-1:0];
      if (reg_addr == A_IEN)  ien_q   <= reg_wdata[7:4];
    end
  end

  always_comb begin
    stat = '0;
    stat[STAT_LEM]  = lem_flag;
    stat[STAT_CA]   = cond_hit[0];
    stat[STAT_CB]   = cond_hit[1];
    stat[STAT_USER] = |sense_q;
  end

  always_comb begin
    rd_d = '0;
    case (reg_addr)
      A_STAT:  rd_d = stat;
      A_CNT:   rd_d = cnt;
      A_CONDA: rd_d = DW'(cond_a[0]);
      A_MASKA: rd_d = DW'(mask_a[0]);
      A_CONDB: rd_d = DW'(cond_a[1]);
      A_MASKB: rd_d = DW'(mask_a[1]);
      A_USER:  rd_d = DW'(sense_q);
      default: rd_d = {ien_q, {(DW-4){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_d;
      irq_q   <= |(stat[7:4] & ien_q);
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq);
  // R9
  sense_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sense_q == '0) |-> !stat[STAT_USER]);
  // R10
  low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_STAT) |=> (reg_rdata[3:0] == 4'h0));
endmodule

// File: tb/link_irq_agg_test.sv
`timescale 1ns/1ps
module link_irq_agg_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       err_pulse = 1'b0;
  logic [7:0] rca_evt = 8'h00;
  logic [7:0] rcb_evt = 8'h00;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit probe = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  link_irq_agg uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_pulse(err_pulse),
    .rca_evt(rca_evt), .rcb_evt(rcb_evt), .irq(irq)
  );

  // monitor: compares read data with the scoreboard queue
  always @(posedge clk) begin
    if (probe) begin
      #1;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty, actual %h expected none", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_addr = a; probe = 1'b1;
    @(negedge clk);
    probe = 1'b0;
  endtask

  task automatic err_n(input int n);
    for (int i = 0; i < n; i++) begin
      err_pulse = 1'b1;
      @(negedge clk);
    end
    err_pulse = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(3'd0, 8'h10, "R1 status");
    rd(3'd1, 8'h00, "R1 counter");
    rd(3'd3, 8'h00, "R1 mask A");
    rd(3'd7, 8'h00, "R1 enable");
    // R5 clear while count is zero
    wr(3'd0, 8'h10);
    rd(3'd0, 8'h10, "R5 clear at zero");
    // R2 load, R4 clear
    wr(3'd1, 8'h03);
    rd(3'd1, 8'h03, "R2 load/R11 read");
    wr(3'd0, 8'h10);
    rd(3'd0, 8'h00, "R4 clear nonzero");
    // R3 decrement
    err_n(2);
    rd(3'd1, 8'h01, "R3 decrement");
    rd(3'd0, 8'h00, "R4 not yet zero");
    err_n(1);
    rd(3'd0, 8'h10, "R4 reaches zero");
    err_n(2);
    rd(3'd1, 8'h00, "R3 saturate");
    // R5 race: error to zero and clear together
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h10);
    rd(3'd0, 8'h00, "R4 cleared at one");
    err_pulse = 1'b1;
    wr(3'd0, 8'h10);
    err_pulse = 1'b0;
    rd(3'd0, 8'h10, "R5 race set wins");
    // R6 masked condition A
    rca_evt = 8'h04; @(negedge clk); rca_evt = 8'h00;
    rd(3'd0, 8'h10, "R6 unmasked");
    wr(3'd3, 8'h04);
    rd(3'd0, 8'h30, "R6 masked on");
    wr(3'd0, 8'hF0);
    rd(3'd0, 8'h30, "R6 write ignored");
    // R7 event vs clear same cycle
    rd(3'd2, 8'h04, "R7 sticky");
    rca_evt = 8'h04;
    wr(3'd2, 8'h04);
    rca_evt = 8'h00;
    rd(3'd2, 8'h04, "R7 event wins");
    wr(3'd2, 8'h04);
    rd(3'd2, 8'h00, "R7 clear");
    rd(3'd0, 8'h10, "R6 follows clear");
    // R8 condition B
    rcb_evt = 8'h81; @(negedge clk); rcb_evt = 8'h00;
    wr(3'd5, 8'h80);
    rd(3'd0, 8'h50, "R8 masked on");
    wr(3'd5, 8'h00);
    rd(3'd0, 8'h10, "R8 masked off");
    wr(3'd4, 8'h81);
    rd(3'd4, 8'h00, "R8 cleared");
    // R9 sense bits
    wr(3'd6, 8'h02);
    rd(3'd0, 8'h90, "R9 sense1");
    wr(3'd6, 8'h01);
    rd(3'd0, 8'h90, "R9 sense0");
    wr(3'd6, 8'h00);
    rd(3'd0, 8'h10, "R9 both zero");
    // R10 interrupt gating
    wr(3'd7, 8'h2F);
    rd(3'd7, 8'h20, "R10 enable low bits");
    chk_irq(1'b0, "R10 masked cause");
    wr(3'd7, 8'h10);
    chk_irq(1'b0, "R10 one cycle lag");
    @(negedge clk);
    chk_irq(1'b1, "R10 threshold enabled");
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h10);
    @(negedge clk);
    chk_irq(1'b0, "R10 cause cleared");
    wr(3'd7, 8'h80);
    wr(3'd6, 8'h01);
    @(negedge clk);
    chk_irq(1'b1, "R10 user enabled");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule